// File: doc/BRIEF.md
# Masked Pattern Match Trigger Unit

The unit watches a wide bus of discrete signals. On every clock it compares the bus against two independent sets of programmable value and mask words. The first set raises a trace-pattern event and the second set raises a cross-trigger output. Each result can also ask for a timestamp. Software programs everything through a simple 32-bit write port. That port holds the global enable, a reporting style for each set, and the timestamp enables.

The pattern side can report in two ways. It can report a match on every cycle the match holds, or only on the cycle a match starts. The trigger side can drive a level that follows the match, or a single-cycle pulse when a match begins. All outputs come from registers. Timestamp generation, trace packet formatting and any edge-detection stage sit outside this unit.

Top module: `mpm_trigger_unit`

## Requirements
- R1: After reset all four outputs are low. The configuration resets as follows: enable 0, trigger pulse mode 0, pattern timestamp enable 0, pattern edge mode 0, trigger timestamp enable 1, and every value and mask word 0.
- R2: A comparison set whose mask words are all zero never reports a match, whatever is on `sig_in`.
- R3: Words are written with `cfg_addr[5:3]` selecting the group and `cfg_addr[2:0]` selecting the word. The groups are 2 for pattern value, 3 for pattern mask, 4 for trigger value and 5 for trigger mask. Word i covers `sig_in[32*i+31:32*i]`. A set matches when every bit whose mask bit is 1 equals its value bit. Bits whose mask bit is 0 are ignored.
- R4: The pattern set and the trigger set are fully independent. Programming one set never changes the outputs of the other.
- R5: Mode word at address 1, bit 1, is the pattern edge mode. With edge mode 0, `pat_evt` is high on every cycle the pattern matches. With edge mode 1, `pat_evt` is high only on the first cycle of a run of matches.
- R6: A write to address 1 stores edge mode 1 only if bit 0 (pattern timestamp enable) of the same write is 1. Otherwise edge mode is stored as 0.
- R7: Control word at address 0, bit 1, is the trigger pulse mode. With pulse mode 1, `trig_out` is a one-cycle pulse when a trigger match begins. With pulse mode 0, `trig_out` follows the match as a level.
- R8: `pat_ts_req` is high exactly when `pat_evt` is high and address 1 bit 0 is set. `trig_ts_req` is high exactly when `trig_out` is high and address 1 bit 2 is set. Each request is in the same cycle as its event.
- R9: Address 0 bit 0 is the global enable. While it is 0, neither event output is raised. After it is set again, a match already in progress counts as a new start.
- R10: Outputs are registered. Each output reflects `sig_in` and the configuration as sampled at the previous rising edge. A write applies to inputs sampled from the following edge onward.
- R11: Writes to addresses outside the map have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| sig_in | input | 256 | Monitored discrete signal bus |
| pat_evt | output | 1 | Trace-pattern event |
| pat_ts_req | output | 1 | Timestamp request for the pattern event |
| trig_out | output | 1 | Cross-trigger output |
| trig_ts_req | output | 1 | Timestamp request for the trigger |

## Verification
Every result is due exactly one rising edge after the `sig_in` value and configuration that caused it. A configuration write affects only inputs sampled after the edge that stores it. The driver applies one input and an optional write on each falling edge. In the same step it computes the expected four output bits from a model that still uses the configuration before that write, and queues them. The monitor takes one entry from the queue just after each following rising edge. This keeps every comparison aligned to the one-cycle latency, including the cycles where writes and matches overlap.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
   localparam int unsigned CFG_AW  = 6;
   localparam int unsigned CFG_IW  = 3;

   typedef enum logic [2:0] {
      GRP_CTRL = 3'd0,
      GRP_PVAL = 3'd2,
      GRP_PMSK = 3'd3,
      GRP_TVAL = 3'd4,
      GRP_TMSK = 3'd5
   } grp_e;

   localparam logic [CFG_IW-1:0] IDX_CTRL = 3'd0;
   localparam logic [CFG_IW-1:0] IDX_MODE = 3'd1;

   typedef struct packed {
      logic en;
      logic trig_pulse;
      logic patt_ts;
      logic patt_edge;
      logic trig_ts;
   } ctl_s;
endpackage

// File: rtl/mpm_cfg_regs.sv
module mpm_cfg_regs
   import mpm_pkg::*;
#(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned NWORDS = 8,
   localparam int unsigned BUS_W = REG_W * NWORDS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [CFG_AW-1:0]   addr,
   input  logic [REG_W-1:0]    wdata,
   output ctl_s                ctl,
   output logic [BUS_W-1:0]    pval,
   output logic [BUS_W-1:0]    pmsk,
   output logic [BUS_W-1:0]    tval,
   output logic [BUS_W-1:0]    tmsk
);
   logic [2:0]        grp;
   logic [CFG_IW-1:0] idx;

   assign grp = addr[CFG_AW-1:CFG_IW];
   assign idx = addr[CFG_IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl <= '{en: 1'b0, trig_pulse: 1'b0, patt_ts: 1'b0,
                  patt_edge: 1'b0, trig_ts: 1'b1};
      end else if (we && grp == GRP_CTRL) begin
         if (idx == IDX_CTRL) begin
            ctl.en         <= wdata[0];
            ctl.trig_pulse <= wdata[1];
         end else if (idx == IDX_MODE) begin
            ctl.patt_ts   <= wdata[0];
            ctl.patt_edge <= wdata[1] & wdata[0];
            ctl.trig_ts   <= wdata[2];
         end
      end
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic hit;
      assign hit = we && (idx == CFG_IW'(w));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pval[w*REG_W +: REG_W] <= '0;
            pmsk[w*REG_W +: REG_W] <= '0;
            tval[w*REG_W +: REG_W] <= '0;
            tmsk[w*REG_W +: REG_W] <= '0;
         end else if (hit) begin
            if (grp == GRP_PVAL) pval[w*REG_W +: REG_W] <= wdata;
            if (grp == GRP_PMSK) pmsk[w*REG_W +: REG_W] <= wdata;
            if (grp == GRP_TVAL) tval[w*REG_W +: REG_W] <= wdata;
            if (grp == GRP_TMSK) tmsk[w*REG_W +: REG_W] <= wdata;
         end
      end
   end
endmodule

// File: rtl/mpm_masked_cmp.sv
module mpm_masked_cmp #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned NWORDS = 8,
   localparam int unsigned BUS_W = REG_W * NWORDS
) (
   input  logic [BUS_W-1:0] data,
   input  logic [BUS_W-1:0] value,
   input  logic [BUS_W-1:0] mask,
   output logic             match
);
   logic [NWORDS-1:0] word_ok;
   logic [NWORDS-1:0] word_used;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [REG_W-1:0] diff;
      assign diff         = (data[w*REG_W +: REG_W] ^ value[w*REG_W +: REG_W])
                            & mask[w*REG_W +: REG_W];
      assign word_ok[w]   = ~|diff;
      assign word_used[w] = |mask[w*REG_W +: REG_W];
   end

   assign match = (&word_ok) & (|word_used);
endmodule

// File: rtl/mpm_reporter.sv
module mpm_reporter (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic match,
   input  logic edge_mode,
   input  logic ts_en,
   output logic evt,
   output logic ts_req
);
   logic prev_q;
   logic live;
   logic fire;

   assign live = en & match;
   assign fire = live & (~edge_mode | ~prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         evt    <= 1'b0;
         ts_req <= 1'b0;
      end else begin
         prev_q <= live;
         evt    <= fire;
         ts_req <= fire & ts_en;
      end
   end
endmodule

// File: rtl/mpm_trigger_unit.sv
module mpm_trigger_unit
   import mpm_pkg::*;
#(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned NWORDS = 8,
   localparam int unsigned BUS_W = REG_W * NWORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic [BUS_W-1:0]  sig_in,
   output logic              pat_evt,
   output logic              pat_ts_req,
   output logic              trig_out,
   output logic              trig_ts_req
);
   if (NWORDS > (1 << CFG_IW)) begin : g_bad_words
      $error("NWORDS exceeds the word index field");
   end
   if (REG_W < 3) begin : g_bad_width
      $error("REG_W too narrow for the mode word");
   end

   ctl_s             ctl;
   logic [BUS_W-1:0] pval, pmsk, tval, tmsk;
   logic             p_match, t_match;

   mpm_cfg_regs #(.REG_W(REG_W), .NWORDS(NWORDS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .ctl(ctl),
      .pval(pval), .pmsk(pmsk), .tval(tval), .tmsk(tmsk)
   );

   mpm_masked_cmp #(.REG_W(REG_W), .NWORDS(NWORDS)) u_pcmp (
      .data(sig_in), .value(pval), .mask(pmsk), .match(p_match)
   );

   mpm_masked_cmp #(.REG_W(REG_W), .NWORDS(NWORDS)) u_tcmp (
      .data(sig_in), .value(tval), .mask(tmsk), .match(t_match)
   );

   mpm_reporter u_prep (
      .clk(clk), .rst_n(rst_n), .en(ctl.en), .match(p_match),
      .edge_mode(ctl.patt_edge), .ts_en(ctl.patt_ts),
      .evt(pat_evt), .ts_req(pat_ts_req)
   );

   mpm_reporter u_trep (
      .clk(clk), .rst_n(rst_n), .en(ctl.en), .match(t_match),
      .edge_mode(ctl.trig_pulse), .ts_en(ctl.trig_ts),
      .evt(trig_out), .ts_req(trig_ts_req)
   );
endmodule

// File: rtl/mpm_checker.sv
module mpm_checker (
   input logic clk,
   input logic rst_n,
   input logic ctl_en,
   input logic trig_pulse,
   input logic patt_ts_en,
   input logic trig_ts_en,
   input logic pat_evt,
   input logic pat_ts,
   input logic trig_out,
   input logic trig_ts
);
   a_r8_pat_ts_needs_evt: assert property (@(posedge clk) disable iff (!rst_n)
      pat_ts |-> pat_evt);

   a_r8_trig_ts_needs_out: assert property (@(posedge clk) disable iff (!rst_n)
      trig_ts |-> trig_out);

   a_r8_pat_ts_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(patt_ts_en) |-> !pat_ts);

   a_r8_trig_ts_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(trig_ts_en) |-> !trig_ts);

   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_en) |-> !(pat_evt || trig_out));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_out && trig_pulse && $past(trig_pulse)) |=> !trig_out);
endmodule

bind mpm_trigger_unit mpm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_en(ctl.en), .trig_pulse(ctl.trig_pulse),
   .patt_ts_en(ctl.patt_ts), .trig_ts_en(ctl.trig_ts),
   .pat_evt(pat_evt), .pat_ts(pat_ts_req),
   .trig_out(trig_out), .trig_ts(trig_ts_req)
);

// File: tb/mpm_trigger_unit_test.sv
`timescale 1ns/1ps
module mpm_trigger_unit_test;
   localparam int RW = 32;
   localparam int NW = 8;
   localparam int BW = RW * NW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_addr = '0;
   logic [RW-1:0] cfg_wdata = '0;
   logic [BW-1:0] sig_in = '0;
   logic          pat_evt, pat_ts_req, trig_out, trig_ts_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   mpm_trigger_unit uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .sig_in(sig_in), .pat_evt(pat_evt),
      .pat_ts_req(pat_ts_req), .trig_out(trig_out), .trig_ts_req(trig_ts_req)
   );

   // bench model of the configuration
   logic [RW-1:0] m_pv [NW];
   logic [RW-1:0] m_pm [NW];
   logic [RW-1:0] m_tv [NW];
   logic [RW-1:0] m_tm [NW];
   logic m_en, m_tpulse, m_pts, m_pedge, m_tts, m_pprev, m_tprev;

   logic [3:0] expq [$];
   string      tagq [$];

   function automatic logic set_hit(input logic [BW-1:0] d,
                                    input logic [RW-1:0] v [NW],
                                    input logic [RW-1:0] m [NW]);
      logic any = 1'b0;
      logic ok  = 1'b1;
      for (int w = 0; w < NW; w++) begin
         if (m[w] != '0) any = 1'b1;
         if (((d[w*RW +: RW] ^ v[w]) & m[w]) != '0) ok = 1'b0;
      end
      return any & ok;
   endfunction

   function automatic logic [BW-1:0] rnd();
      logic [BW-1:0] r;
      for (int w = 0; w < NW; w++) r[w*RW +: RW] = $urandom;
      return r;
   endfunction

   task automatic model_reset();
      for (int w = 0; w < NW; w++) begin
         m_pv[w] = '0; m_pm[w] = '0; m_tv[w] = '0; m_tm[w] = '0;
      end
      m_en = 0; m_tpulse = 0; m_pts = 0; m_pedge = 0; m_tts = 1;
      m_pprev = 0; m_tprev = 0;
   endtask

   // one cycle: drive input and optional write, queue expected result
   task automatic cyc(input logic [BW-1:0] d, input logic we,
                      input logic [5:0] a, input logic [RW-1:0] wd,
                      input string tag);
      logic ph, th, fp, ft;
      @(negedge clk);
      sig_in = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
      ph = m_en & set_hit(d, m_pv, m_pm);
      th = m_en & set_hit(d, m_tv, m_tm);
      fp = ph & (!m_pedge | !m_pprev);
      ft = th & (!m_tpulse | !m_tprev);
      expq.push_back({fp, fp & m_pts, ft, ft & m_tts});
      tagq.push_back(tag);
      m_pprev = ph; m_tprev = th;
      if (we) begin
         case (a[5:3])
            3'd0: if (a[2:0] == 3'd0) begin
                     m_en = wd[0]; m_tpulse = wd[1];
                  end else if (a[2:0] == 3'd1) begin
                     m_pts = wd[0]; m_pedge = wd[1] & wd[0]; m_tts = wd[2];
                  end
            3'd2: m_pv[a[2:0]] = wd;
            3'd3: m_pm[a[2:0]] = wd;
            3'd4: m_tv[a[2:0]] = wd;
            3'd5: m_tm[a[2:0]] = wd;
            default: ;
         endcase
      end
   endtask

   task automatic idle(input logic [BW-1:0] d, input string tag);
      cyc(d, 1'b0, 6'd0, '0, tag);
   endtask

   task automatic wr(input logic [5:0] a, input logic [RW-1:0] wd, input string tag);
      cyc(rnd(), 1'b1, a, wd, tag);
   endtask

   // monitor: compare one queued item after every rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (expq.size() > 0) begin
            logic [3:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            n_tests++;
            if ({pat_evt, pat_ts_req, trig_out, trig_ts_req} !== e) begin
               n_fail++;
               $display("FAIL %s: got %b expected %b (pat,pts,trig,tts)", t,
                        {pat_evt, pat_ts_req, trig_out, trig_ts_req}, e);
            end
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   function automatic logic [BW-1:0] with_t(input logic [BW-1:0] d, input logic m);
      logic [BW-1:0] r = d;
      r[15:0] = m ? 16'h1234 : 16'h1235;
      return r;
   endfunction

   function automatic logic [BW-1:0] with_p(input logic [BW-1:0] d, input logic m);
      logic [BW-1:0] r = d;
      r[255:248] = m ? 8'hAB : 8'hAA;
      return r;
   endfunction

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state of the outputs
      n_tests++;
      if ({pat_evt, pat_ts_req, trig_out, trig_ts_req} !== 4'b0000) begin
         n_fail++;
         $display("FAIL R1: got %b expected 0000",
                  {pat_evt, pat_ts_req, trig_out, trig_ts_req});
      end
      rst_n = 1'b1;

      // R2: enabled, masks all zero: no match on any input
      wr(6'h00, 32'h1, "R9 enable");
      for (int i = 0; i < 6; i++) idle(rnd(), "R2 empty masks");
      idle('0, "R2 zero input");
      idle('1, "R2 ones input");

      // R11: writes outside the map have no effect
      wr(6'h38, 32'hFFFF_FFFF, "R11 unmapped");
      wr(6'h02, 32'hFFFF_FFFF, "R11 unmapped ctrl");
      idle('1, "R11 no match after unmapped writes");

      // R3: trigger mask word0 low half, value 0x1234, level mode; trigger ts on from reset
      wr(6'h28, 32'h0000_FFFF, "R3 trig mask");
      wr(6'h20, 32'hFFFF_1234, "R3 trig value");
      for (int i = 0; i < 4; i++) idle(with_t(rnd(), 1'b1), "R3 R8 R4 trig match level");
      idle(with_t(rnd(), 1'b0), "R3 one bit off");
      idle(with_t(rnd(), 1'b1), "R3 match again");

      // R4: pattern set on word 7 top byte
      wr(6'h1F, 32'hFF00_0000, "R4 pat mask");
      wr(6'h17, 32'hAB00_0000, "R4 pat value");
      idle(with_t(with_p(rnd(), 1'b1), 1'b0), "R4 pattern only");
      idle(with_t(with_p(rnd(), 1'b0), 1'b1), "R4 trigger only");
      idle(with_t(with_p(rnd(), 1'b1), 1'b1), "R4 both");

      // R5 R8: pattern ts on, edge mode, trigger ts off
      wr(6'h01, 32'h3, "R5 mode write");
      for (int i = 0; i < 4; i++) idle(with_p(rnd(), 1'b1), "R5 R8 edge mode run");
      idle(with_p(rnd(), 1'b0), "R5 gap");
      idle(with_p(rnd(), 1'b1), "R5 new start");

      // R6: type without ts enable is stored as 0
      wr(6'h01, 32'h2, "R6 mode write");
      for (int i = 0; i < 3; i++) idle(with_p(rnd(), 1'b1), "R6 level despite type bit");

      // R7: trigger pulse mode, trigger ts back on
      wr(6'h01, 32'h4, "R7 mode write");
      wr(6'h00, 32'h3, "R7 ctrl write");
      for (int i = 0; i < 4; i++) idle(with_t(rnd(), 1'b1), "R7 R8 pulse run");
      idle(with_t(rnd(), 1'b0), "R7 gap");
      idle(with_t(rnd(), 1'b1), "R7 second pulse");

      // R9: disable stops everything, re-enable is a new start
      wr(6'h00, 32'h2, "R9 disable");
      for (int i = 0; i < 3; i++) idle(with_t(with_p(rnd(), 1'b1), 1'b1), "R9 disabled");
      wr(6'h00, 32'h3, "R9 reenable");
      idle(with_t(with_p(rnd(), 1'b1), 1'b1), "R9 start after enable");
      idle(with_t(with_p(rnd(), 1'b1), 1'b1), "R9 held");

      // R10: write and match in the same cycle use the old configuration
      cyc(with_t(rnd(), 1'b1), 1'b1, 6'h00, 32'h1, "R10 write cycle");
      idle(with_t(rnd(), 1'b1), "R10 new mode applies");

      // mixed random run
      for (int i = 0; i < 60; i++) begin
         logic [BW-1:0] d;
         d = with_t(with_p(rnd(), $urandom_range(0, 1) == 1), $urandom_range(0, 1) == 1);
         if (i % 9 == 4) cyc(d, 1'b1, 6'h01, $urandom_range(0, 7), "R5 R8 random mode");
         else if (i % 11 == 7) cyc(d, 1'b1, 6'h00, $urandom_range(0, 3), "R7 R9 random ctrl");
         else idle(d, "R3 R10 random");
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule